// File: doc/BRIEF.md
# Compare-Driven Port Override Mask

This block lets a single master compare event update several lines of an 8-bit port together. It holds four byte-wide registers on a small bus: the port data latch, the port direction register, an override mask, and an action-data register. When the compare match strobe is high, every line whose mask bit is set loads its bit from the action-data register. Lines whose mask bit is clear keep their value.

A line with its mask bit set is always driven as an output. This holds whatever its direction bit says. The stored direction bit is never altered, so clearing the mask bit gives the line back its programmed direction. Only the upper mask bits, from `MASK_LSB` to the top, exist in hardware. The lower mask bits read as zero and ignore writes. Timer counting is not part of this block; the compare strobe comes in already decoded.

The register map uses `bus_addr`: 0 is port data, 1 is direction, 2 is override mask, 3 is action data. Writes take effect on the rising clock edge where `bus_wr` is high. `bus_rdata` shows the addressed register combinationally.

Top module: `cpo_port_override`

## Requirements
- R1: After reset, all four registers read 0x00, `pad_oe` is 0x00 and `pad_out` is 0x00.
- R2: Mask bits 2..0 always read as zero, and writing ones to them has no effect (writing 0xFF reads back 0xF8).
- R3: The mask can be written at any time, and the next read returns the written value ANDed with 0xF8.
- R4: `pad_oe` equals the direction register ORed with the mask, bit for bit.
- R5: On a clock edge with `cmp_hit` high, each line whose mask bit is 1 takes the matching bit of the action-data register (address 3) into its output latch.
- R6: On a compare, lines whose mask bit is 0 keep their latch value; with the mask at 0x00 a compare changes nothing.
- R7: If a port-data write (address 0) and a compare fall in the same cycle, masked lines take the action-data bit and unmasked lines take the written bit.
- R8: Mask writes never change the direction register's stored value, and clearing the mask returns `pad_oe` to the direction register.
- R9: A port-data write without a compare updates `pad_out` and the readback at address 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select (0 data, 1 direction, 2 mask, 3 action data) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| cmp_hit | input | 1 | Master compare match strobe, one cycle per event |
| pad_oe | output | 8 | Effective per-line output enable |
| pad_out | output | 8 | Per-line output latch value |

## Verification
The assertions assume that `cmp_hit` and `bus_wr` are clean single-cycle levels sampled at the rising edge. They also assume that the mask in force for a compare is the value registered before that edge, not a mask write landing in the same cycle. The bench changes every input only on the falling edge. It never issues a mask write and a compare in the same cycle. Same-cycle collisions are exercised only between port-data writes and compares. Within those limits, the sweep covers every implemented mask combination under several direction, data and action patterns.

// File: rtl/cpo_pkg.sv
package cpo_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_MASK = 2'd2,
    SEL_ACT  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cpo_mask_reg.sv
module cpo_mask_reg #(
  parameter int W        = 8,
  parameter int MASK_LSB = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] impl_bits();
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (i >= MASK_LSB);
    return m;
  endfunction

  localparam logic [W-1:0] IMPL = impl_bits();

  logic [W-1:0] store_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  store_q <= '0;
    else if (wr) store_q <= wdata & IMPL;
  end
  assign q = store_q;

  // R3
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> q == ($past(wdata) & IMPL));
  // R2
  mask_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (q & ~IMPL) == '0);
endmodule

// File: rtl/cpo_line_latch.sv
module cpo_line_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_wr,
  input  logic sw_bit,
  input  logic cmp_hit,
  input  logic sel,
  input  logic act_bit,
  output logic q
);
  logic cmp_take;
  assign cmp_take = cmp_hit & sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= 1'b0;
    else if (cmp_take) q <= act_bit;
    else if (sw_wr)    q <= sw_bit;
  end

  // R5
  cmp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit && sel) |=> q == $past(act_bit));
  // R6
  unsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit && !sel && !sw_wr) |=> $stable(q));
  // R7
  collide_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit && !sel && sw_wr) |=> q == $past(sw_bit));
endmodule

// File: rtl/cpo_port_override.sv
module cpo_port_override #(
  parameter int W        = 8,
  parameter int MASK_LSB = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   bus_addr,
  input  logic         bus_wr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         cmp_hit,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out
);
  import cpo_pkg::*;

  function automatic logic [W-1:0] eff_dir(input logic [W-1:0] dir, input logic [W-1:0] msk);
    return dir | msk;
  endfunction

  logic wr_data, wr_dir, wr_mask, wr_act;
  assign wr_data = bus_wr && (bus_addr == SEL_DATA);
  assign wr_dir  = bus_wr && (bus_addr == SEL_DIR);
  assign wr_mask = bus_wr && (bus_addr == SEL_MASK);
  assign wr_act  = bus_wr && (bus_addr == SEL_ACT);

  logic [W-1:0] dir_q, act_q, mask_q, line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      act_q <= '0;
    end else begin
      if (wr_dir) dir_q <= bus_wdata;
      if (wr_act) act_q <= bus_wdata;
    end
  end

  cpo_mask_reg #(.W(W), .MASK_LSB(MASK_LSB)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr(wr_mask), .wdata(bus_wdata), .q(mask_q)
  );

  for (genvar i = 0; i < W; i++) begin : g_line
    cpo_line_latch u_latch (
      .clk(clk), .rst_n(rst_n),
      .sw_wr(wr_data), .sw_bit(bus_wdata[i]),
      .cmp_hit(cmp_hit), .sel(mask_q[i]), .act_bit(act_q[i]),
      .q(line_q[i])
    );
  end

  assign pad_out = line_q;
  assign pad_oe  = eff_dir(dir_q, mask_q);

  always_comb begin
    case (reg_sel_e'(bus_addr))
      SEL_DATA: bus_rdata = line_q;
      SEL_DIR:  bus_rdata = dir_q;
      SEL_MASK: bus_rdata = mask_q;
      default:  bus_rdata = act_q;
    endcase
  end

  // R8
  dir_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_dir) |=> $stable(dir_q));
  // R4
  oe_cover_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & mask_q) == mask_q);
endmodule

// File: tb/cpo_port_override_bench.sv
module cpo_port_override_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cmp_hit = 1'b0;
  logic [7:0] pad_oe, pad_out;

  int checks = 0, fails = 0;
  logic [7:0] m_data, m_dir, m_mask, m_act;

  always #2 clk = ~clk;

  cpo_port_override u_cpo_port_override (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_hit(cmp_hit),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic [1:0] a, input logic [7:0] d, input logic c);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; cmp_hit = c;
    @(negedge clk);
    bus_wr = 1'b0; cmp_hit = 1'b0;
    #1;
  endtask

  task automatic rd(input string tag, input logic [1:0] a, input logic [7:0] exp);
    bus_addr = a; #1;
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1
    rd("R1 data", 2'd0, 8'h00); rd("R1 dir", 2'd1, 8'h00);
    rd("R1 mask", 2'd2, 8'h00); rd("R1 act", 2'd3, 8'h00);
    check("R1 oe", pad_oe, 8'h00); check("R1 out", pad_out, 8'h00);

    // R2 R3: every write value
    for (int v = 0; v < 256; v++) begin
      cyc(1'b1, 2'd2, v[7:0], 1'b0);
      rd("R2 R3 mask readback", 2'd2, v[7:0] & 8'hF8);
    end
    cyc(1'b1, 2'd2, 8'h07, 1'b0);
    rd("R2 low bits ignored", 2'd2, 8'h00);

    m_data = 8'h00;
    for (int m = 0; m < 32; m++) begin
      m_mask = 8'(m << 3);
      m_dir  = 8'((m * 37 + 5) & 255);
      cyc(1'b1, 2'd1, m_dir, 1'b0);
      cyc(1'b1, 2'd2, m_mask, 1'b0);
      // R4
      check("R4 oe", pad_oe, m_dir | m_mask);
      rd("R8 dir kept", 2'd1, m_dir);
      // R9
      m_data = 8'((m * 91 + 17) & 255);
      cyc(1'b1, 2'd0, m_data, 1'b0);
      check("R9 out", pad_out, m_data);
      rd("R9 readback", 2'd0, m_data);
      // R5 R6
      m_act = ~m_data ^ 8'(m);
      cyc(1'b1, 2'd3, m_act, 1'b0);
      cyc(1'b0, 2'd0, 8'h00, 1'b1);
      m_data = (m_act & m_mask) | (m_data & ~m_mask);
      check(m == 0 ? "R6 no effect" : "R5 R6 compare", pad_out, m_data);
      // R7
      m_act = 8'((m * 53) & 255);
      cyc(1'b1, 2'd3, m_act, 1'b0);
      begin
        logic [7:0] w;
        w = 8'((m * 29 + 200) & 255);
        cyc(1'b1, 2'd0, w, 1'b1);
        m_data = (m_act & m_mask) | (w & ~m_mask);
        check("R7 collision", pad_out, m_data);
      end
      // R8
      cyc(1'b1, 2'd2, 8'h00, 1'b0);
      check("R8 oe restored", pad_oe, m_dir);
      rd("R8 dir stored", 2'd1, m_dir);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule